// File: doc/BRIEF.md
# Reference Clock Pre-Divider to Comparison Rate

This block sits between the reference clock inputs and a phase comparator. Each reference channel is sampled into the system clock domain. Its active edges are turned into single-cycle events, and a per-channel down-counter reduces those events to a comparison-rate pulse. A per-channel configuration byte selects one of three modes. Pass-through emits one pulse per active reference edge. Spot-frequency mode looks up the ratio that brings a supported reference frequency down to 8 kHz. Manual mode divides by a programmed N plus one.

A single N value serves every channel. It is loaded as two bytes through a small write port and checked for range before it is accepted. One shared control picks whether rising or falling reference edges count. The pulse outputs are plain event strobes. They carry no data and take no back-pressure, so there is no valid/ready pairing on them. The comparator must accept every pulse in the cycle it appears.

Top module: `ref_prediv`

## Requirements
- R1: While reset is held and in the first cycle after it, every bit of `cmp_pulse` is 0. The committed N starts at 1, and every channel counter starts at terminal count.
- R2: A config byte with bits 7 and 6 both clear selects pass-through mode. Each active edge on that channel's reference gives exactly one pulse. The pulse is high in the cycle that follows the third rising clock edge after the reference transition.
- R3: Config bit 7 set selects manual mode. The channel emits one pulse for every N+1 active reference edges.
- R4: Config bit 7 clear with bit 6 set selects spot-frequency mode. Config bits 3:0 carry a frequency code, and the ratio is the reference frequency divided by 8 kHz: code 0 (8 kHz) gives 1, 1 (2.048 MHz) gives 256, 2 (1.544 MHz) gives 193, 3 (6.48 MHz) gives 810, 4 (19.44 MHz) gives 2430, 5 (25.92 MHz) gives 3240, 6 (38.88 MHz) gives 4860, 7 (51.84 MHz) gives 6480, and 8 (77.76 MHz) gives 9720.
- R5: When bits 7 and 6 are both set, manual mode wins.
- R6: In spot-frequency mode, a code of 9 to 15 produces no pulses. The counter waits at terminal count until a supported ratio is in force.
- R7: N is loaded in two writes. A write with `n_wr_hi` stores the upper byte. A following write with `n_wr_lo` supplies the lower byte and commits the 16-bit value. The one committed N is used by every channel in manual mode.
- R8: A candidate N of 0 or above 12499 is discarded, and the previously committed N stays in force.
- R9: A change of ratio, whether from N or from the config byte, is taken only when the counter reloads at terminal count. The period already under way finishes at its old length, so no short period is produced.
- R10: `edge_fall` = 0 makes rising reference edges active, and 1 makes falling edges active, for all channels.
- R11: Each pulse lasts one cycle. The first active edge after reset produces a pulse, and later pulses follow at the full ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | NCH | Reference clocks, one per channel, asynchronous |
| cfg_flat | input | NCH*8 | Config bytes, channel c at bits 8c+7:8c |
| edge_fall | input | 1 | 0 = rising edges active, 1 = falling edges active |
| n_wdata | input | 8 | Byte for the N write port |
| n_wr_hi | input | 1 | Store `n_wdata` as the upper byte of the candidate N |
| n_wr_lo | input | 1 | Take `n_wdata` as the lower byte and commit if in range |
| cmp_pulse | output | NCH | Comparison-rate pulse per channel |

## Verification
Each pulse is due a fixed three clock edges after the reference transition that causes it. Two synchroniser stages and the counter register make up that delay. The stimulus task applies each transition at a falling clock edge and queues the exact clock count at which the pulse must show. A monitor compares the pulses at falling clock edges against that queue. It reports an early, unexpected or overdue pulse with its actual and expected cycle. Configuration and N writes are made only after every in-flight transition has settled, so each ratio change lands where the model expects the reload.

// File: rtl/prediv_pkg.sv
package prediv_pkg;

  localparam int unsigned CNT_W = 14;

  typedef logic [CNT_W-1:0] ratio_t;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_SPOT   = 2'd1,
    MODE_MANUAL = 2'd2
  } div_mode_e;

  // Manual has priority over spot-frequency mode.
  function automatic div_mode_e decode_mode(input logic [7:0] cfg);
    if (cfg[7])      return MODE_MANUAL;
    else if (cfg[6]) return MODE_SPOT;
    else             return MODE_PASS;
  endfunction

  // Edges of the reference per 8 kHz period; 0 marks an unsupported code.
  function automatic ratio_t spot_ratio(input logic [3:0] code);
    case (code)
      4'd0:    return ratio_t'(1);
      4'd1:    return ratio_t'(256);
      4'd2:    return ratio_t'(193);
      4'd3:    return ratio_t'(810);
      4'd4:    return ratio_t'(2430);
      4'd5:    return ratio_t'(3240);
      4'd6:    return ratio_t'(4860);
      4'd7:    return ratio_t'(6480);
      4'd8:    return ratio_t'(9720);
      default: return ratio_t'(0);
    endcase
  endfunction

endpackage

// File: rtl/prediv_edge_sync.sv
module prediv_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_raw,
  input  logic fall_sel,
  output logic evt
);

  // sh[SYNC_STAGES-1] is the synchronised level, sh[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_STAGES-1:0], ref_raw};
  end

  logic lvl_now, lvl_prev;
  assign lvl_now  = sh[SYNC_STAGES-1];
  assign lvl_prev = sh[SYNC_STAGES];

  always_comb begin
    if (fall_sel) evt = lvl_prev & ~lvl_now;
    else          evt = lvl_now & ~lvl_prev;
  end

  AST_EVT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!evt || (fall_sel != $past(fall_sel)))); // R11

endmodule

// File: rtl/prediv_n_reg.sv
module prediv_n_reg
  import prediv_pkg::*;
#(
  parameter int unsigned N_MAX   = 12499,
  parameter int unsigned N_RESET = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] wdata,
  input  logic       wr_hi,
  input  logic       wr_lo,
  output ratio_t     n_q
);

  logic [7:0]  hi_q;
  logic [15:0] cand;
  logic        cand_ok;

  assign cand    = {hi_q, wdata};
  assign cand_ok = (cand != 16'd0) && (32'(cand) <= N_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      n_q  <= ratio_t'(N_RESET);
    end else begin
      if (wr_hi) hi_q <= wdata;
      if (wr_lo && cand_ok) n_q <= cand[CNT_W-1:0];
    end
  end

  AST_N_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q != '0) && (32'(n_q) <= N_MAX)); // R8

  AST_N_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lo |=> $stable(n_q)); // R7

endmodule

// File: rtl/prediv_chan_counter.sv
module prediv_chan_counter
  import prediv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   evt,
  input  ratio_t ratio,
  output logic   pulse
);

  ratio_t cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (evt) begin
        if (cnt == '0) begin
          // Reload point: only here does a new ratio take hold.
          if (ratio != '0) begin
            pulse <= 1'b1;
            cnt   <= ratio - ratio_t'(1);
          end
        end else begin
          cnt <= cnt - ratio_t'(1);
        end
      end
    end
  end

  AST_PULSE_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(evt)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cnt != '0) |=> (cnt == $past(cnt) - ratio_t'(1)) && !pulse); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> ($stable(cnt) && !pulse)); // R11

  AST_ZERO_RATIO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cnt == '0 && ratio == '0) |=> (!pulse && cnt == '0)); // R6

endmodule

// File: rtl/ref_prediv.sv
module ref_prediv
  import prediv_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned N_MAX       = 12499,
  parameter int unsigned N_RESET     = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ref_in,
  input  logic [NCH*8-1:0] cfg_flat,
  input  logic             edge_fall,
  input  logic [7:0]       n_wdata,
  input  logic             n_wr_hi,
  input  logic             n_wr_lo,
  output logic [NCH-1:0]   cmp_pulse
);

  ratio_t n_q;

  prediv_n_reg #(
    .N_MAX   (N_MAX),
    .N_RESET (N_RESET)
  ) u_nreg (
    .clk   (clk),
    .rst_n (rst_n),
    .wdata (n_wdata),
    .wr_hi (n_wr_hi),
    .wr_lo (n_wr_lo),
    .n_q   (n_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic      evt;
    div_mode_e mode;
    ratio_t    ratio;

    always_comb begin
      mode = decode_mode(cfg_flat[g*8 +: 8]);
      case (mode)
        MODE_MANUAL: ratio = n_q + ratio_t'(1);
        MODE_SPOT:   ratio = spot_ratio(cfg_flat[g*8 +: 4]);
        default:     ratio = ratio_t'(1);
      endcase
    end

    prediv_edge_sync #(
      .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_raw  (ref_in[g]),
      .fall_sel (edge_fall),
      .evt      (evt)
    );

    prediv_chan_counter u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .ratio (ratio),
      .pulse (cmp_pulse[g])
    );

    AST_MANUAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flat[g*8+7] |-> (ratio != '0)); // R5
  end

endmodule

// File: tb/ref_prediv_bench.sv
module ref_prediv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ref_in = '0;
  logic [15:0] cfg_flat = '0;
  logic        edge_fall = 1'b0;
  logic [7:0]  n_wdata = '0;
  logic        n_wr_hi = 1'b0;
  logic        n_wr_lo = 1'b0;
  logic [1:0]  cmp_pulse;

  ref_prediv u_ref_prediv (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .cfg_flat  (cfg_flat),
    .edge_fall (edge_fall),
    .n_wdata   (n_wdata),
    .n_wr_hi   (n_wr_hi),
    .n_wr_lo   (n_wr_lo),
    .cmp_pulse (cmp_pulse)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench model state
  int       m_cnt [2];
  int       m_n = 1;
  bit       fall_m = 1'b0;
  logic [7:0] cfg_m [2];
  int       q0 [$];
  int       q1 [$];

  function automatic int exp_ratio(input int ch);
    int khz;
    if (cfg_m[ch][7]) return m_n + 1;
    if (!cfg_m[ch][6]) return 1;
    case (cfg_m[ch][3:0])
      4'd0: khz = 8;
      4'd1: khz = 2048;
      4'd2: khz = 1544;
      4'd3: khz = 6480;
      4'd4: khz = 19440;
      4'd5: khz = 25920;
      4'd6: khz = 38880;
      4'd7: khz = 51840;
      4'd8: khz = 77760;
      default: khz = 0;
    endcase
    return khz / 8;
  endfunction

  task automatic model_step(input int ch);
    int r;
    if (m_cnt[ch] == 0) begin
      r = exp_ratio(ch);
      if (r != 0) begin
        if (ch == 0) q0.push_back(cyc + 3);
        else         q1.push_back(cyc + 3);
        m_cnt[ch] = r - 1;
      end
    end else begin
      m_cnt[ch] = m_cnt[ch] - 1;
    end
  endtask

  task automatic drive(input logic [1:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_in = ref_in | mask;
      if (!fall_m) for (int c = 0; c < 2; c++) if (mask[c]) model_step(c);
      repeat (2) @(negedge clk);
      ref_in = ref_in & ~mask;
      if (fall_m) for (int c = 0; c < 2; c++) if (mask[c]) model_step(c);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic settle_check();
    repeat (6) @(negedge clk);
    checks++;
    if (q0.size() != 0 || q1.size() != 0) begin
      fails++;
      $display("FAIL %s: pending pulses actual ch0=%0d ch1=%0d expected 0/0",
               cur_req, q0.size(), q1.size());
    end
  endtask

  task automatic set_cfg(input int ch, input logic [7:0] v);
    repeat (4) @(negedge clk);
    cfg_flat[ch*8 +: 8] = v;
    cfg_m[ch] = v;
  endtask

  task automatic write_n(input int v);
    repeat (4) @(negedge clk);
    n_wdata = v[15:8]; n_wr_hi = 1'b1;
    @(negedge clk);
    n_wr_hi = 1'b0; n_wdata = v[7:0]; n_wr_lo = 1'b1;
    @(negedge clk);
    n_wr_lo = 1'b0;
    if (v >= 1 && v <= 12499) m_n = v;
  endtask

  // Monitor: compare pulses against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q0.size() != 0 && q0[0] < cyc) begin
        fails++; checks++;
        $display("FAIL %s: ch0 missing pulse actual none expected cycle %0d", cur_req, q0[0]);
        void'(q0.pop_front());
      end
      while (q1.size() != 0 && q1[0] < cyc) begin
        fails++; checks++;
        $display("FAIL %s: ch1 missing pulse actual none expected cycle %0d", cur_req, q1[0]);
        void'(q1.pop_front());
      end
      if (cmp_pulse[0]) begin
        checks++;
        if (q0.size() != 0 && q0[0] == cyc) void'(q0.pop_front());
        else begin
          fails++;
          $display("FAIL %s: ch0 pulse actual cycle %0d expected %0d", cur_req, cyc,
                   (q0.size() != 0) ? q0[0] : -1);
        end
      end
      if (cmp_pulse[1]) begin
        checks++;
        if (q1.size() != 0 && q1[0] == cyc) void'(q1.pop_front());
        else begin
          fails++;
          $display("FAIL %s: ch1 pulse actual cycle %0d expected %0d", cur_req, cyc,
                   (q1.size() != 0) ? q1[0] : -1);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cnt[0] = 0; m_cnt[1] = 0;
    cfg_m[0] = 8'h00; cfg_m[1] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (cmp_pulse !== 2'b00) begin
      fails++;
      $display("FAIL R1: pulses in reset actual %b expected 00", cmp_pulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cmp_pulse !== 2'b00) begin
      fails++;
      $display("FAIL R1: pulses after reset actual %b expected 00", cmp_pulse);
    end

    // R2 / R11: pass-through, first edge after reset pulses
    cur_req = "R2";
    drive(2'b01, 5);
    settle_check();

    // R3 / R7: manual mode with N=3, ratio 4
    cur_req = "R3";
    write_n(3);
    set_cfg(0, 8'h80);
    drive(2'b01, 10);
    settle_check();

    // R10: falling edge active
    cur_req = "R10";
    repeat (4) @(negedge clk);
    edge_fall = 1'b1; fall_m = 1'b1;
    drive(2'b01, 8);
    settle_check();
    repeat (4) @(negedge clk);
    edge_fall = 1'b0; fall_m = 1'b0;

    // R5: both mode bits set, manual wins over code 4
    cur_req = "R5";
    set_cfg(0, 8'hC4);
    drive(2'b01, 8);
    settle_check();

    // R9: N changed mid-period, applies after next terminal count
    cur_req = "R9";
    drive(2'b01, 2);
    write_n(1);
    drive(2'b01, 9);
    settle_check();

    // R8: out-of-range N rejected, ratio stays 2
    cur_req = "R8";
    write_n(0);
    write_n(12500);
    drive(2'b01, 7);
    settle_check();

    // R6: unsupported spot code on ch1 gives no pulses
    cur_req = "R6";
    set_cfg(1, 8'h4F);
    drive(2'b10, 10);
    settle_check();

    // R7: shared N drives both channels
    cur_req = "R7";
    set_cfg(1, 8'h80);
    drive(2'b11, 6);
    settle_check();

    // R4: spot-frequency ratios on ch1
    cur_req = "R4";
    set_cfg(1, 8'h40);
    drive(2'b10, 4);
    set_cfg(1, 8'h42);
    drive(2'b10, 400);
    set_cfg(1, 8'h44);
    drive(2'b10, 2700);
    settle_check();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule